// File: doc/BRIEF.md
# PCI Read Command Selector

This block sits inside a bus-master DMA engine and decides, burst by burst, which PCI read command a transfer should use: plain Memory Read, Memory Read Line or Memory Read Multiple. A transfer request supplies a start address, a byte count and a flag marking an instruction fetch. When a request is accepted, the block also captures the configuration at its inputs: cache mode enable, read-line enable, read-multiple enable, the cache line size and the programmed burst size. It then presents one burst per clock cycle, each with a command code, an address and a byte length. It advances the address and reduces the remaining count until the transfer is finished, and then pulses a done output.

In cache mode the cached commands are only used when the cache line size is legal and no larger than the burst size, the current address sits on a line boundary, and enough bytes remain. Under the same conditions an unaligned burst is cut short at the next line boundary, so that later bursts start aligned. With cache mode off, read-line enable alone selects Memory Read Line. Bus signalling, parity, retries and data movement belong to other blocks.

Top module: `pci_rdcmd_sel`

## Requirements
- R1: A transfer flagged as an instruction fetch uses Memory Read (code 4'b0110) on every burst, whatever the configuration bits are.
- R2: With cache mode off, every non-fetch burst uses Memory Read Line (4'b1110) when read-line enable is set and Memory Read (4'b0110) otherwise. Read-multiple enable has no effect in this mode.
- R3: With cache mode on, the line size is legal only when its value (in 32-bit words) is 2, 4, 8 or 16 and is at most the effective burst size. A burst size input of 0 counts as 1. When the line size is not legal, every burst uses Memory Read.
- R4: With cache mode on and a legal line size, a burst uses Memory Read Line when all of these hold: read-line enable is set, the address modulo (4 x line size) is zero, and the remaining byte count is at least 4 x line size. Read Multiple must not also qualify (R6).
- R5: With cache mode on and a legal line size, a burst uses Memory Read Multiple (4'b1100) when all of these hold: read-multiple enable is set, the address is line aligned, and the remaining byte count is at least 4 x the effective burst size.
- R6: When Read Multiple and Read Line both qualify, Read Multiple is issued. If neither qualifies in cache mode, the burst uses Memory Read.
- R7: A burst's length in bytes is the smallest of three values: the remaining count, 4 x the effective burst size, and, when cache mode is on with a legal line size and the address is unaligned, the bytes left to the next line boundary.
- R8: A request is accepted on a clock edge while the block is idle. Starting on the next cycle, burst_valid is high on each cycle until the transfer ends. Each burst's address equals the previous burst's address plus its length, and the remaining count falls by the same length.
- R9: done is high for exactly one cycle: the cycle after the last burst, or the cycle after accepting a zero-byte request, which produces no bursts.
- R10: req_valid and the request fields are ignored while a transfer is in progress.
- R11: Configuration inputs are captured when a request is accepted. Changes to them during a transfer do not affect its bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_cache_en | input | 1 | Cache mode enable |
| cfg_line_en | input | 1 | Read-line enable (mode register bit 3) |
| cfg_mult_en | input | 1 | Read-multiple enable (mode register bit 2) |
| cfg_line_words | input | 8 | Cache line size in 32-bit words |
| cfg_burst_words | input | 8 | Burst size in 32-bit words; 0 is treated as 1 |
| req_valid | input | 1 | Start a transfer (accepted only while idle) |
| req_addr | input | 32 | Transfer start byte address |
| req_bytes | input | 16 | Transfer byte count |
| req_opfetch | input | 1 | Transfer is an instruction fetch |
| busy | output | 1 | Transfer in progress |
| burst_valid | output | 1 | A burst is presented this cycle |
| burst_cmd | output | 4 | PCI command code for the burst |
| burst_addr | output | 32 | Burst start byte address |
| burst_len | output | 16 | Burst length in bytes |
| done | output | 1 | One-cycle pulse when the transfer ends |

## Verification
Directed transfers each isolate one command rule. An instruction fetch with every enable set shows that the fetch override wins. Transfers with cache mode off separate the read-line shortcut from the ignored read-multiple enable. Illegal and oversized line sizes confirm the fallback to Memory Read. Aligned transfers are sized so that one qualifies for Read Line only, and another for both cached commands, which exposes the priority order. An unaligned start address in cache mode shows the shortened first burst and the cached command on the aligned burst that follows. Random transfers then mix line sizes (legal and illegal), burst sizes including zero, addresses biased toward line boundaries, and short counts that cross the thresholds. Some of these transfers also change the configuration and raise stray requests during the walk, to show that the captured state is kept.

// File: rtl/rdsel_pkg.sv
package rdsel_pkg;
  localparam int CFG_W = 8;
  localparam int LB_W  = CFG_W + 2;

  localparam logic [3:0] CMD_MEMRD  = 4'b0110;
  localparam logic [3:0] CMD_RDLINE = 4'b1110;
  localparam logic [3:0] CMD_RDMULT = 4'b1100;

  // burst size with zero mapped to one word
  function automatic logic [CFG_W-1:0] burst_eff(input logic [CFG_W-1:0] bw);
    return (bw == '0) ? CFG_W'(1) : bw;
  endfunction

  function automatic logic [LB_W-1:0] words_to_bytes(input logic [CFG_W-1:0] w);
    return {w, 2'b00};
  endfunction

  function automatic logic line_size_ok(input logic [CFG_W-1:0] lw,
                                        input logic [CFG_W-1:0] bw);
    logic pow;
    pow = (lw == CFG_W'(2)) || (lw == CFG_W'(4)) ||
          (lw == CFG_W'(8)) || (lw == CFG_W'(16));
    return pow && (lw <= burst_eff(bw));
  endfunction

  // byte offset of an address inside its cache line
  function automatic logic [LB_W-1:0] line_offset(input logic [LB_W-1:0] alo,
                                                  input logic [CFG_W-1:0] lw);
    return alo & (words_to_bytes(lw) - LB_W'(1));
  endfunction
endpackage

// File: rtl/rdsel_qual.sv
module rdsel_qual
  import rdsel_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              opf_i,
  input  logic              cache_en_i,
  input  logic              line_en_i,
  input  logic              mult_en_i,
  input  logic [CFG_W-1:0]  line_w_i,
  input  logic [CFG_W-1:0]  burst_w_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [3:0]        cmd_o,
  output logic              legal_o,
  output logic              aligned_o,
  output logic              line_ok_o,
  output logic              mult_ok_o
);
  logic [CNT_W-1:0] line_bytes_c;
  logic [CNT_W-1:0] burst_bytes_c;

  always_comb begin
    line_bytes_c  = CNT_W'(words_to_bytes(line_w_i));
    burst_bytes_c = CNT_W'(words_to_bytes(burst_eff(burst_w_i)));
    legal_o   = line_size_ok(line_w_i, burst_w_i);
    aligned_o = (line_offset(addr_i[LB_W-1:0], line_w_i) == '0);
    mult_ok_o = cache_en_i && mult_en_i && legal_o && aligned_o &&
                (cnt_i >= burst_bytes_c);
    line_ok_o = cache_en_i && line_en_i && legal_o && aligned_o &&
                (cnt_i >= line_bytes_c);
    if (opf_i)            cmd_o = CMD_MEMRD;
    else if (!cache_en_i) cmd_o = line_en_i ? CMD_RDLINE : CMD_MEMRD;
    else if (mult_ok_o)   cmd_o = CMD_RDMULT;
    else if (line_ok_o)   cmd_o = CMD_RDLINE;
    else                  cmd_o = CMD_MEMRD;
  end
endmodule

// File: rtl/rdsel_span.sv
module rdsel_span
  import rdsel_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              cache_en_i,
  input  logic              legal_i,
  input  logic [CFG_W-1:0]  line_w_i,
  input  logic [CFG_W-1:0]  burst_w_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [CNT_W-1:0]  len_o,
  output logic [LB_W-1:0]   to_bnd_o,
  output logic              bounded_o
);
  logic [LB_W-1:0] off_c;
  logic [LB_W-1:0] cap_c;

  always_comb begin
    off_c     = line_offset(addr_i[LB_W-1:0], line_w_i);
    to_bnd_o  = words_to_bytes(line_w_i) - off_c;
    bounded_o = cache_en_i && legal_i && (off_c != '0);
    cap_c     = words_to_bytes(burst_eff(burst_w_i));
    if (bounded_o && (to_bnd_o < cap_c)) cap_c = to_bnd_o;
    len_o = (cnt_i < CNT_W'(cap_c)) ? cnt_i : CNT_W'(cap_c);
  end
endmodule

// File: rtl/rdsel_walker.sv
module rdsel_walker
  import rdsel_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [CNT_W-1:0]  req_bytes_i,
  input  logic              req_opf_i,
  input  logic              cfg_cache_en_i,
  input  logic              cfg_line_en_i,
  input  logic              cfg_mult_en_i,
  input  logic [CFG_W-1:0]  cfg_line_w_i,
  input  logic [CFG_W-1:0]  cfg_burst_w_i,
  input  logic [CNT_W-1:0]  len_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              opf_o,
  output logic              cache_en_o,
  output logic              line_en_o,
  output logic              mult_en_o,
  output logic [CFG_W-1:0]  line_w_o,
  output logic [CFG_W-1:0]  burst_w_o
);
  logic accept_c;
  logic last_c;

  assign accept_c = !busy_o && req_valid_i;
  assign last_c   = busy_o && (len_i == cnt_o);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_o     <= 1'b0;
      done_o     <= 1'b0;
      addr_o     <= '0;
      cnt_o      <= '0;
      opf_o      <= 1'b0;
      cache_en_o <= 1'b0;
      line_en_o  <= 1'b0;
      mult_en_o  <= 1'b0;
      line_w_o   <= '0;
      burst_w_o  <= '0;
    end else begin
      done_o <= 1'b0;
      if (accept_c) begin
        addr_o     <= req_addr_i;
        cnt_o      <= req_bytes_i;
        opf_o      <= req_opf_i;
        cache_en_o <= cfg_cache_en_i;
        line_en_o  <= cfg_line_en_i;
        mult_en_o  <= cfg_mult_en_i;
        line_w_o   <= cfg_line_w_i;
        burst_w_o  <= cfg_burst_w_i;
        if (req_bytes_i == '0) done_o <= 1'b1;
        else                   busy_o <= 1'b1;
      end else if (busy_o) begin
        addr_o <= addr_o + ADDR_W'(len_i);
        cnt_o  <= cnt_o - len_i;
        if (last_c) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end

  AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (len_i != '0) && (len_i <= cnt_o)); // R7
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && $past(busy_o) |-> cnt_o == $past(cnt_o) - $past(len_i)); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o); // R9
  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && $past(busy_o) |-> $stable(line_w_o) && $stable(burst_w_o) &&
    $stable(cache_en_o)); // R11
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && $past(busy_o) |-> addr_o == $past(addr_o) + ADDR_W'($past(len_i))); // R10
endmodule

// File: rtl/pci_rdcmd_sel.sv
module pci_rdcmd_sel
  import rdsel_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_cache_en,
  input  logic              cfg_line_en,
  input  logic              cfg_mult_en,
  input  logic [CFG_W-1:0]  cfg_line_words,
  input  logic [CFG_W-1:0]  cfg_burst_words,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CNT_W-1:0]  req_bytes,
  input  logic              req_opfetch,
  output logic              busy,
  output logic              burst_valid,
  output logic [3:0]        burst_cmd,
  output logic [ADDR_W-1:0] burst_addr,
  output logic [CNT_W-1:0]  burst_len,
  output logic              done
);
  logic              w_opf, w_cache, w_line, w_mult;
  logic [CFG_W-1:0]  w_line_w, w_burst_w;
  logic [CNT_W-1:0]  w_cnt;
  logic              q_legal, q_aligned, q_line_ok, q_mult_ok;
  logic [LB_W-1:0]   s_to_bnd;
  logic              s_bounded;

  rdsel_walker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_walk (
    .clk(clk), .rst_n(rst_n),
    .req_valid_i(req_valid), .req_addr_i(req_addr), .req_bytes_i(req_bytes),
    .req_opf_i(req_opfetch),
    .cfg_cache_en_i(cfg_cache_en), .cfg_line_en_i(cfg_line_en),
    .cfg_mult_en_i(cfg_mult_en), .cfg_line_w_i(cfg_line_words),
    .cfg_burst_w_i(cfg_burst_words),
    .len_i(burst_len),
    .busy_o(busy), .done_o(done), .addr_o(burst_addr), .cnt_o(w_cnt),
    .opf_o(w_opf), .cache_en_o(w_cache), .line_en_o(w_line), .mult_en_o(w_mult),
    .line_w_o(w_line_w), .burst_w_o(w_burst_w)
  );

  rdsel_qual #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_qual (
    .opf_i(w_opf), .cache_en_i(w_cache), .line_en_i(w_line), .mult_en_i(w_mult),
    .line_w_i(w_line_w), .burst_w_i(w_burst_w), .addr_i(burst_addr), .cnt_i(w_cnt),
    .cmd_o(burst_cmd), .legal_o(q_legal), .aligned_o(q_aligned),
    .line_ok_o(q_line_ok), .mult_ok_o(q_mult_ok)
  );

  rdsel_span #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_span (
    .cache_en_i(w_cache), .legal_i(q_legal), .line_w_i(w_line_w),
    .burst_w_i(w_burst_w), .addr_i(burst_addr), .cnt_i(w_cnt),
    .len_o(burst_len), .to_bnd_o(s_to_bnd), .bounded_o(s_bounded)
  );

  assign burst_valid = busy;

  AST_FETCH_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
    burst_valid && w_opf |-> burst_cmd == CMD_MEMRD); // R1
  AST_MULT_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    burst_valid && burst_cmd == CMD_RDMULT |-> w_cache && w_mult && q_legal && q_aligned); // R5
  AST_MULT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    burst_valid && !w_opf && q_mult_ok && q_line_ok |-> burst_cmd == CMD_RDMULT); // R6
  AST_ILLEGAL_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
    burst_valid && w_cache && !q_legal |-> burst_cmd == CMD_MEMRD); // R3
  AST_NO_LINE_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
    burst_valid && s_bounded |-> burst_len <= CNT_W'(s_to_bnd)); // R7
endmodule

// File: tb/tb_pci_rdcmd_sel.sv
module tb_pci_rdcmd_sel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_cache_en = 1'b0, cfg_line_en = 1'b0, cfg_mult_en = 1'b0;
  logic [7:0]  cfg_line_words = '0, cfg_burst_words = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [15:0] req_bytes = '0;
  logic        req_opfetch = 1'b0;
  logic        busy, burst_valid, done;
  logic [3:0]  burst_cmd;
  logic [31:0] burst_addr;
  logic [15:0] burst_len;

  int n_chk = 0;
  int n_bad = 0;
  int seed = 1234;
  int cyc = 0;

  pci_rdcmd_sel dut (.*);

  always #2 clk = ~clk;

  function automatic void report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual cycles %0d expected below 150000", cyc);
      report();
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int eff_b(int bw);
    return (bw == 0) ? 1 : bw;
  endfunction

  function automatic bit legal_line(int lw, int bw);
    return (lw == 2 || lw == 4 || lw == 8 || lw == 16) && lw <= eff_b(bw);
  endfunction

  function automatic int model_cmd(bit op, bit ce, bit le, bit me, int lw, int bw,
                                   longint addr, int cnt, output string tag);
    bit al;
    if (op) begin tag = "R1"; return 6; end
    if (!ce) begin tag = "R2"; return le ? 14 : 6; end
    if (!legal_line(lw, bw)) begin tag = "R3"; return 6; end
    al = (addr % (lw * 4)) == 0;
    if (me && al && cnt >= eff_b(bw) * 4) begin
      tag = (le && cnt >= lw * 4) ? "R6" : "R5";
      return 12;
    end
    if (le && al && cnt >= lw * 4) begin tag = "R4"; return 14; end
    tag = "R4";
    return 6;
  endfunction

  function automatic int model_len(bit ce, int lw, int bw, longint addr, int cnt);
    int cap, off;
    cap = eff_b(bw) * 4;
    if (ce && legal_line(lw, bw)) begin
      off = int'(addr % (lw * 4));
      if (off != 0 && (lw * 4 - off) < cap) cap = lw * 4 - off;
    end
    return (cnt < cap) ? cnt : cap;
  endfunction

  task automatic run_xfer(input logic [31:0] a, input int n, input bit op,
                          input bit ce, input bit le, input bit me,
                          input int lw, input int bw, input bit noisy);
    logic [31:0] m_addr;
    int m_cnt, ecmd, elen;
    string tag;
    @(negedge clk);
    cfg_cache_en = ce; cfg_line_en = le; cfg_mult_en = me;
    cfg_line_words = 8'(lw); cfg_burst_words = 8'(bw);
    req_addr = a; req_bytes = 16'(n); req_opfetch = op; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    m_addr = a; m_cnt = n;
    if (n == 0) begin
      check(done === 1'b1 && burst_valid === 1'b0, "R9 zero-byte done", {done, burst_valid}, 2'b10);
      @(negedge clk);
      check(done === 1'b0, "R9 single pulse", done, 0);
      return;
    end
    while (m_cnt > 0) begin
      ecmd = model_cmd(op, ce, le, me, lw, bw, m_addr, m_cnt, tag);
      elen = model_len(ce, lw, bw, m_addr, m_cnt);
      check(burst_valid === 1'b1, "R8 burst valid", burst_valid, 1);
      check(burst_cmd == 4'(ecmd), noisy ? {tag, " R11 cmd"} : {tag, " cmd"}, burst_cmd, ecmd);
      check(burst_len == 16'(elen), noisy ? "R11 len" : "R7 len", burst_len, elen);
      check(burst_addr == m_addr, noisy ? "R10 addr" : "R8 addr", burst_addr, m_addr);
      if (elen == 0) elen = m_cnt;
      m_addr = m_addr + 32'(elen);
      m_cnt = m_cnt - elen;
      if (noisy && m_cnt > 0) begin
        cfg_cache_en = 1'($urandom); cfg_line_en = 1'($urandom); cfg_mult_en = 1'($urandom);
        cfg_line_words = 8'($urandom); cfg_burst_words = 8'($urandom);
        req_valid = 1'($urandom); req_addr = $urandom; req_bytes = 16'($urandom);
        req_opfetch = 1'($urandom);
      end else begin
        req_valid = 1'b0;
      end
      @(negedge clk);
    end
    check(done === 1'b1 && burst_valid === 1'b0, "R9 done after last", {done, burst_valid}, 2'b10);
    @(negedge clk);
    check(done === 1'b0, "R9 single pulse", done, 0);
  endtask

  initial begin
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && burst_valid === 1'b0 && done === 1'b0, "R8 reset idle",
          {busy, burst_valid, done}, 0);
    rst_n = 1'b1;

    // R1: fetch with all enables in a qualifying setup
    run_xfer(32'h1000, 128, 1'b1, 1'b1, 1'b1, 1'b1, 4, 16, 1'b0);
    // R2: cache off, read-line on, unaligned start
    run_xfer(32'h1006, 40, 1'b0, 1'b0, 1'b1, 1'b0, 4, 4, 1'b0);
    // R2: cache off, only read-multiple on
    run_xfer(32'h2000, 64, 1'b0, 1'b0, 1'b0, 1'b1, 4, 16, 1'b0);
    // R3: illegal line size, and line larger than burst
    run_xfer(32'h3000, 96, 1'b0, 1'b1, 1'b1, 1'b1, 3, 16, 1'b0);
    run_xfer(32'h3000, 96, 1'b0, 1'b1, 1'b1, 1'b1, 16, 8, 1'b0);
    // R4: read line only (count below burst)
    run_xfer(32'h4000, 20, 1'b0, 1'b1, 1'b1, 1'b1, 4, 16, 1'b0);
    // R5 R6: both qualify, then tail
    run_xfer(32'h5000, 80, 1'b0, 1'b1, 1'b1, 1'b1, 4, 16, 1'b0);
    // R7: unaligned start in cache mode
    run_xfer(32'h600C, 100, 1'b0, 1'b1, 1'b1, 1'b0, 8, 16, 1'b0);
    // R9: zero bytes
    run_xfer(32'h7000, 0, 1'b0, 1'b1, 1'b1, 1'b1, 4, 8, 1'b0);
    // R10 R11: noisy inputs during walk
    run_xfer(32'h8004, 200, 1'b0, 1'b1, 1'b1, 1'b1, 4, 8, 1'b1);

    for (int i = 0; i < 300; i++) begin
      int lsel [8] = '{0, 1, 2, 3, 4, 8, 16, 32};
      int bsel [7] = '{0, 1, 2, 4, 8, 16, 32};
      int lw, bw, n;
      logic [31:0] a;
      lw = lsel[$urandom_range(7)];
      bw = bsel[$urandom_range(6)];
      a = $urandom;
      if ($urandom_range(2) != 0) a = a & ~32'h3F;
      if ($urandom_range(3) == 0) a = a + 32'(4 * $urandom_range(15));
      n = ($urandom_range(4) == 0) ? $urandom_range(8) : $urandom_range(300);
      run_xfer(a, n, ($urandom_range(9) == 0), 1'($urandom), 1'($urandom), 1'($urandom),
               lw, bw, ($urandom_range(4) == 0));
    end

    report();
    $finish;
  end
endmodule